// File: doc/BRIEF.md
# I2C Passive Bus Watch Capture

This block listens to an I2C bus through a front end that has already turned SDA and SCL activity into single-cycle event strobes: start, repeated start, stop, and byte-complete, which comes with the byte value and the acknowledge bit. It never drives the bus. Each completed byte is latched into a capture word. The capture word also records whether the byte was the first one after a start or after a repeated start, and whether it was not acknowledged. A host drains the capture word with a read strobe.

Status outputs give the host a view of the bus. One output says a captured byte is waiting. One records that a byte was lost. One follows an open transaction. One latches the return of the bus to idle. When stretch mode is enabled, a byte that completes while the previous one is still unread is not dropped. It is parked in a one-entry hold slot, and the block raises a request to hold SCL low. The request stays up until the host reads.

Top module: `i2c_bus_watch`

## Requirements
- R1: One cycle after a byte strobe with `mon_en` high, `cap_word` carries the byte in bits 7:0, the start tag in bit 8, the repeated-start tag in bit 9 and the not-acknowledged bit in bit 10.
- R2: `rdy` rises in the cycle after a capture. A `rd_strobe` while `rdy` is set clears it, unless a parked byte is waiting.
- R3: A byte that completes while `rdy` is set, with no read in the same cycle and no free hold slot, is dropped and sets `ovf`. `ovf` stays set until `ovf_clr`, and a new loss in the same cycle as `ovf_clr` wins.
- R4: A start tags only the next captured byte, with bit 8. A repeated start tags it with bit 9 and not bit 8. If both strobes come together, the repeated start wins.
- R5: `act` sets on a start or a repeated start and clears on a stop. A start in the same cycle as a stop leaves `act` set.
- R6: `idle` sets on a stop that ends an active transaction and stays set until `idle_clr`.
- R7: With `stretch_en` high, a byte that would otherwise be lost is parked, `stretch_req` goes high and `ovf` is not set. The next read shows the parked byte in `cap_word`, keeps `rdy` set and drops `stretch_req`.
- R8: While `mon_en` is low, bus strobes change neither the capture word, the tags, `act` nor `idle`.
- R9: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_en | input | 1 | Watch enable; bus strobes are ignored while low |
| stretch_en | input | 1 | Allow parking a byte and requesting SCL hold |
| ev_start | input | 1 | Start condition strobe |
| ev_rstart | input | 1 | Repeated start strobe |
| ev_byte | input | 1 | Byte complete strobe |
| ev_data | input | DATA_W | Byte value that goes with `ev_byte` |
| ev_nack | input | 1 | Acknowledge bit was high (not acknowledged) |
| ev_stop | input | 1 | Stop condition strobe |
| rd_strobe | input | 1 | Host reads the capture word |
| ovf_clr | input | 1 | Write-one clear of `ovf` |
| idle_clr | input | 1 | Write-one clear of `idle` |
| cap_word | output | DATA_W+3 | Capture word: nack, restart tag, start tag, byte |
| rdy | output | 1 | Unread byte waiting |
| ovf | output | 1 | Byte lost, sticky |
| act | output | 1 | Transaction open |
| idle | output | 1 | Bus returned to idle, sticky |
| stretch_req | output | 1 | Request to hold SCL low |

## Verification
A tag state that is stuck or stale shows up in bits 8 and 9 of the very next capture word, one cycle after the byte strobe. An error in the ready/hold bookkeeping shows within a cycle of the next byte or read: `ovf` rises when it should not, `rdy` falls while a byte is parked, or `stretch_req` hangs after a read. Errors in `act` and `idle` show on the cycle after the stop or start that should have moved them. The bench compares every output on every cycle, so none of these can stay hidden for more than one clock.

// File: rtl/i2c_watch_pkg.sv
package i2c_watch_pkg;
   // extra tag bits carried above the data byte
   localparam int TAG_BITS = 3;

   typedef enum logic [1:0] {
      COND_NONE    = 2'd0,
      COND_START   = 2'd1,
      COND_RESTART = 2'd2
   } cond_e;
endpackage

// File: rtl/i2c_watch_tagger.sv
module i2c_watch_tagger
   import i2c_watch_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic ev_start,
   input  logic ev_rstart,
   input  logic ev_byte,
   output logic tag_start,
   output logic tag_rstart
);
   cond_e cond_q;

   // a byte consumes the pending tag; a condition in the same cycle arms the next byte
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cond_q <= COND_NONE;
      else if (en) begin
         if (ev_rstart)
            cond_q <= COND_RESTART;
         else if (ev_start)
            cond_q <= COND_START;
         else if (ev_byte)
            cond_q <= COND_NONE;
      end
   end

   assign tag_start  = (cond_q == COND_START);
   assign tag_rstart = (cond_q == COND_RESTART);
endmodule

// File: rtl/i2c_watch_bus_state.sv
module i2c_watch_bus_state (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic ev_start,
   input  logic ev_rstart,
   input  logic ev_stop,
   input  logic idle_clr,
   output logic act,
   output logic idle
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act  <= 1'b0;
         idle <= 1'b0;
      end else begin
         if (en && (ev_start || ev_rstart))
            act <= 1'b1;
         else if (en && ev_stop)
            act <= 1'b0;

         if (en && ev_stop && act)
            idle <= 1'b1;
         else if (idle_clr)
            idle <= 1'b0;
      end
   end
endmodule

// File: rtl/i2c_watch_slot.sv
module i2c_watch_slot #(
   parameter int WORD_W     = 11,
   parameter bit STRETCH_OK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_vld,
   input  logic [WORD_W-1:0] cap_w,
   input  logic              rd,
   input  logic              stretch_en,
   input  logic              ovf_clr,
   output logic [WORD_W-1:0] word,
   output logic              rdy,
   output logic              ovf,
   output logic              sreq
);
   logic [WORD_W-1:0] held_w, nxt_word, nxt_held_w;
   logic              held_v, nxt_rdy, nxt_held_v, lose;

   always_comb begin
      nxt_word   = word;
      nxt_rdy    = rdy;
      nxt_held_v = held_v;
      nxt_held_w = held_w;
      lose       = 1'b0;
      // host read first: promote a parked byte or empty the slot
      if (rd && rdy) begin
         if (held_v) begin
            nxt_word   = held_w;
            nxt_held_v = 1'b0;
         end else begin
            nxt_rdy = 1'b0;
         end
      end
      // then the incoming byte
      if (cap_vld) begin
         if (!nxt_rdy) begin
            nxt_word = cap_w;
            nxt_rdy  = 1'b1;
         end else if (STRETCH_OK && stretch_en && !nxt_held_v) begin
            nxt_held_v = 1'b1;
            nxt_held_w = cap_w;
         end else begin
            lose = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word <= '0;
         rdy  <= 1'b0;
         ovf  <= 1'b0;
      end else begin
         word <= nxt_word;
         rdy  <= nxt_rdy;
         if (lose)
            ovf <= 1'b1;
         else if (ovf_clr)
            ovf <= 1'b0;
      end
   end

   generate
      if (STRETCH_OK) begin : g_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               held_v <= 1'b0;
               held_w <= '0;
            end else begin
               held_v <= nxt_held_v;
               held_w <= nxt_held_w;
            end
         end
      end else begin : g_nohold
         assign held_v = 1'b0;
         assign held_w = '0;
      end
   endgenerate

   assign sreq = held_v;
endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch
   import i2c_watch_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter bit STRETCH_OK = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       mon_en,
   input  logic                       stretch_en,
   input  logic                       ev_start,
   input  logic                       ev_rstart,
   input  logic                       ev_byte,
   input  logic [DATA_W-1:0]          ev_data,
   input  logic                       ev_nack,
   input  logic                       ev_stop,
   input  logic                       rd_strobe,
   input  logic                       ovf_clr,
   input  logic                       idle_clr,
   output logic [DATA_W+TAG_BITS-1:0] cap_word,
   output logic                       rdy,
   output logic                       ovf,
   output logic                       act,
   output logic                       idle,
   output logic                       stretch_req
);
   localparam int WORD_W = DATA_W + TAG_BITS;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("i2c_bus_watch: DATA_W must be at least 1");
      end
   endgenerate

   logic tag_s, tag_r;

   i2c_watch_tagger u_tag (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (mon_en),
      .ev_start   (ev_start),
      .ev_rstart  (ev_rstart),
      .ev_byte    (ev_byte),
      .tag_start  (tag_s),
      .tag_rstart (tag_r)
   );

   i2c_watch_bus_state u_bus (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (mon_en),
      .ev_start  (ev_start),
      .ev_rstart (ev_rstart),
      .ev_stop   (ev_stop),
      .idle_clr  (idle_clr),
      .act       (act),
      .idle      (idle)
   );

   i2c_watch_slot #(.WORD_W(WORD_W), .STRETCH_OK(STRETCH_OK)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .cap_vld    (mon_en & ev_byte),
      .cap_w      ({ev_nack, tag_r, tag_s, ev_data}),
      .rd         (rd_strobe),
      .stretch_en (stretch_en),
      .ovf_clr    (ovf_clr),
      .word       (cap_word),
      .rdy        (rdy),
      .ovf        (ovf),
      .sreq       (stretch_req)
   );
endmodule

// File: rtl/i2c_watch_chk.sv
module i2c_watch_chk #(
   parameter int DATA_W     = 8,
   parameter bit STRETCH_OK = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mon_en,
   input logic              stretch_en,
   input logic              ev_start,
   input logic              ev_rstart,
   input logic              ev_byte,
   input logic [DATA_W-1:0] ev_data,
   input logic              ev_nack,
   input logic              ev_stop,
   input logic              rd_strobe,
   input logic              ovf_clr,
   input logic              idle_clr,
   input logic [DATA_W+2:0] cap_word,
   input logic              rdy,
   input logic              ovf,
   input logic              act,
   input logic              idle,
   input logic              stretch_req
);
   // R2
   rdy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdy) |-> $past(mon_en && ev_byte));

   // R3
   loss_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_en && ev_byte && rdy && !rd_strobe && !stretch_en) |=> ovf);

   // R7
   stretch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stretch_req) |-> $past(stretch_en && mon_en && ev_byte && rdy));

   // R7
   stretch_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stretch_req && rd_strobe && !(mon_en && ev_byte)) |=> (!stretch_req && rdy));

   // R5
   stop_drops_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_en && ev_stop && !ev_start && !ev_rstart) |=> !act);

   // R6
   stop_sets_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_en && ev_stop && act) |=> idle);

   // R8
   disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mon_en && !rd_strobe) |=> ($stable(cap_word) && $stable(act)));
endmodule

bind i2c_bus_watch i2c_watch_chk #(.DATA_W(DATA_W), .STRETCH_OK(STRETCH_OK)) u_chk (.*);

// File: tb/i2c_bus_watch_test.sv
`timescale 1ns/1ps
module i2c_bus_watch_test;
   localparam int DW = 8;
   localparam int WW = DW + 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mon_en = 0, stretch_en = 0, ev_start = 0, ev_rstart = 0, ev_byte = 0;
   logic [DW-1:0] ev_data = '0;
   logic ev_nack = 0, ev_stop = 0, rd_strobe = 0, ovf_clr = 0, idle_clr = 0;
   logic [WW-1:0] cap_word;
   logic rdy, ovf, act, idle, stretch_req;

   int checks = 0, errors = 0;
   bit done = 0;

   // expected state, derived from the requirements
   logic m_ts, m_tr, m_rdy, m_ovf, m_act, m_idle, m_hv;
   logic [WW-1:0] m_word, m_hw;

   always #4 clk = ~clk;

   i2c_bus_watch #(.DATA_W(DW)) uut (.*);

   task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, got, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_ts = 0; m_tr = 0; m_rdy = 0; m_ovf = 0; m_act = 0; m_idle = 0; m_hv = 0;
      m_word = '0; m_hw = '0;
   endtask

   task automatic model_step();
      logic [WW-1:0] nw;
      logic lose, old_act;
      lose = 0;
      old_act = m_act;
      nw = {ev_nack, m_tr, m_ts, ev_data};
      // R2 / R7: read empties or promotes
      if (rd_strobe && m_rdy) begin
         if (m_hv) begin m_word = m_hw; m_hv = 0; end
         else m_rdy = 0;
      end
      // R1 / R3 / R7: incoming byte
      if (mon_en && ev_byte) begin
         if (!m_rdy) begin m_word = nw; m_rdy = 1; end
         else if (stretch_en && !m_hv) begin m_hw = nw; m_hv = 1; end
         else lose = 1;
      end
      if (lose) m_ovf = 1;
      else if (ovf_clr) m_ovf = 0;
      // R4: tags
      if (mon_en) begin
         if (ev_rstart) begin m_tr = 1; m_ts = 0; end
         else if (ev_start) begin m_ts = 1; m_tr = 0; end
         else if (ev_byte) begin m_ts = 0; m_tr = 0; end
      end
      // R5 / R6
      if (mon_en && (ev_start || ev_rstart)) m_act = 1;
      else if (mon_en && ev_stop) m_act = 0;
      if (mon_en && ev_stop && old_act) m_idle = 1;
      else if (idle_clr) m_idle = 0;
   endtask

   task automatic compare_all(string ctx);
      chk({"R1 cap_word ", ctx}, 32'(cap_word), 32'(m_word));
      chk({"R2 rdy ", ctx}, 32'(rdy), 32'(m_rdy));
      chk({"R3 ovf ", ctx}, 32'(ovf), 32'(m_ovf));
      chk({"R5 act ", ctx}, 32'(act), 32'(m_act));
      chk({"R6 idle ", ctx}, 32'(idle), 32'(m_idle));
      chk({"R7 stretch_req ", ctx}, 32'(stretch_req), 32'(m_hv));
   endtask

   task automatic clear_in();
      ev_start = 0; ev_rstart = 0; ev_byte = 0; ev_nack = 0; ev_stop = 0;
      rd_strobe = 0; ovf_clr = 0; idle_clr = 0;
   endtask

   // drive after a falling edge, expect after the next rising edge
   task automatic step(string ctx);
      model_step();
      @(negedge clk);
      compare_all(ctx);
      clear_in();
   endtask

   task automatic put_byte(logic [DW-1:0] d, logic nk);
      ev_byte = 1; ev_data = d; ev_nack = nk;
   endtask

   initial begin
      void'($urandom(32'h1C2B_0A55));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R9: reset state
      chk("R9 reset cap_word", 32'(cap_word), 0);
      chk("R9 reset flags", {27'd0, rdy, ovf, act, idle, stretch_req}, 0);

      mon_en = 1;
      // R4: start tags first byte only, bit 8
      ev_start = 1;            step("R4 start");
      put_byte(8'hA5, 0);      step("R4 first byte");
      chk("R4 start tag bit8", 32'(cap_word[10:8]), 32'b001);
      rd_strobe = 1; put_byte(8'h3C, 1); step("R4 second byte untagged");
      chk("R4 no tag, nack bit10", 32'(cap_word[10:8]), 32'b100);
      // R4: repeated start gives bit 9, not bit 8
      ev_rstart = 1;           step("R4 restart");
      rd_strobe = 1;           step("R2 read");
      chk("R2 read clears rdy", 32'(rdy), 0);
      put_byte(8'h81, 0);      step("R4 restart byte");
      chk("R4 restart tag bit9", 32'(cap_word[10:8]), 32'b010);
      // R3: loss with no hold slot, set wins over clear
      put_byte(8'h11, 0); ovf_clr = 1; step("R3 loss vs clear");
      chk("R3 ovf set on loss", 32'(ovf), 1);
      chk("R3 word kept", 32'(cap_word[7:0]), 32'h81);
      ovf_clr = 1;             step("R3 clear");
      // R7: parking and release
      stretch_en = 1;
      put_byte(8'h5A, 0);      step("R7 park");
      chk("R7 stretch up", 32'(stretch_req), 1);
      chk("R7 no ovf when parked", 32'(ovf), 0);
      rd_strobe = 1;           step("R7 release");
      chk("R7 parked byte shown", 32'(cap_word[7:0]), 32'h5A);
      chk("R7 rdy kept", 32'(rdy), 1);
      rd_strobe = 1;           step("R7 drain");
      stretch_en = 0;
      // R6: stop ends transaction
      ev_stop = 1;             step("R6 stop");
      chk("R6 idle set", 32'(idle), 1);
      step("R6 idle held");
      idle_clr = 1;            step("R6 idle clear");
      // R8: disabled ignores events
      mon_en = 0;
      ev_start = 1;            step("R8 start ignored");
      put_byte(8'hEE, 1);      step("R8 byte ignored");
      chk("R8 no capture", 32'(rdy), 0);
      chk("R8 no act", 32'(act), 0);
      mon_en = 1;
      put_byte(8'h42, 0);      step("R8 tag not armed");
      chk("R8 no stale tag", 32'(cap_word[9:8]), 0);

      // constrained random phases
      for (int i = 0; i < 4000; i++) begin
         stretch_en = (i >= 2000);
         mon_en     = ($urandom % 16) != 0;
         ev_start   = ($urandom % 12) == 0;
         ev_rstart  = ($urandom % 20) == 0;
         ev_stop    = ($urandom % 14) == 0;
         ev_byte    = ($urandom % 3) == 0;
         ev_data    = DW'($urandom);
         ev_nack    = ($urandom % 5) == 0;
         rd_strobe  = ($urandom % 4) == 0;
         ovf_clr    = ($urandom % 10) == 0;
         idle_clr   = ($urandom % 8) == 0;
         step("random");
      end

      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule